// File: doc/BRIEF.md
# Auto-Reload Tick Timer

This block supplies a periodic time base, for example the scheduler tick of an operating system. A 24-bit counter counts down. When it has reached zero, the next tick loads a programmable reload value. The step from one to zero raises a sticky count flag. If interrupts are enabled, the flag also drives a level interrupt request. Software picks the count clock: every core clock cycle, or one core cycle in eight. The slow rate comes from a clock-enable pulse, so the whole block stays in the single core clock domain.

Software reaches the block through a small register port. The control register at address 0 holds run, interrupt enable, clock source and the count flag. Address 1 holds the reload value and address 2 holds the current count. Writes take effect on the clock edge of the strobe. Reads are combinational on the selected address.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero, address 3 always reads zero, and `tick_irq` is low.
- R2: With run (control bit 0) and fast source (control bit 2) both set, the current value falls by one on every core clock cycle. When it is at zero, the next tick loads the reload value.
- R3: The count flag (control bit 16) sets on the tick that takes the current value from 1 to 0. With a reload value N, later flags follow every N+1 ticks.
- R4: A read strobe on the control register returns the flag and clears it on that edge. If the flag sets on the same edge, the set wins.
- R5: Any write to the current-value register (address 2) forces the count to 0 and clears the flag. The next tick loads the reload value.
- R6: With a reload value of 0, the counter stays at 0 once it arrives there, and no further flags set.
- R7: `tick_irq` is high exactly while the flag and interrupt enable (control bit 1) are both set. It is a level, so enabling interrupts with the flag already set raises it at once.
- R8: With control bit 2 clear, one tick occurs every 8 core cycles. The divider restarts whenever run is clear, so the first tick comes 8 cycles after the enabling write.
- R9: While run is clear the count holds. A reload write does not change the current count.
- R10: The reload register keeps only 24 bits and reads back zero above them. Unused control bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 reload, 2 current |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (needed for the read-to-clear flag) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| tick_irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check the following. A running fast counter steps down by exactly one. The flag rises only on a 1-to-0 step and drops only after a control read or a current-value write. A current-value write leaves zero and a clear flag. A zero reload pins the counter, a stopped counter holds still, and the interrupt never appears without the flag. The bench scenarios show the timing the properties cannot express. These are the 24-cycle period and first-tick delay of the divided source, the reload-plus-one flag period, the set-over-clear collision on one edge, and the masking of bits above 24 on reload and control writes.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
// Shared register selects, control bit positions and control state type.
// Assumes a two-bit register select.
package tick_timer_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    localparam int BIT_RUN    = 0;
    localparam int BIT_IRQ_EN = 1;
    localparam int BIT_FAST   = 2;
    localparam int BIT_FLAG   = 16;

    typedef struct packed {
        logic fast;
        logic irq_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tick_timer_prescale.sv
`timescale 1ns/1ps
// Clock-enable divider: emits a one-cycle pulse every DIV core cycles while
// run is set, and restarts its phase whenever run is clear.
// Assumes DIV >= 1; DIV of 1 degenerates to a pulse on every running cycle.
module tick_timer_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pulse
);

    generate
        if (DIV <= 1) begin : g_pass
            assign pulse = run;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;

            // Phase counter wraps at DIV-1 and sits at zero while stopped.
            always_ff @(posedge clk) begin
                if (!rst_n)              phase <= '0;
                else if (!run)           phase <= '0;
                else if (phase == LAST)  phase <= '0;
                else                     phase <= phase + 1'b1;
            end

            assign pulse = run && (phase == LAST);
        end
    endgenerate

endmodule

// File: rtl/tick_timer_regs.sv
`timescale 1ns/1ps
// Register file: holds control bits and reload value, decodes strobes for
// the counter, and multiplexes read data.
// Assumes DATA_W > CNT_W and DATA_W > BIT_FLAG.
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cur,
    input  logic              flag,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              wr_cur,
    output logic              rd_ctrl,
    output logic [DATA_W-1:0] rdata
);

    logic wdata_high_unused;
    assign wdata_high_unused = |wdata[DATA_W-1:CNT_W];

    // Control register update on a write to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr && reg_sel_e'(sel) == SEL_CTRL) begin
            ctrl.run    <= wdata[BIT_RUN];
            ctrl.irq_en <= wdata[BIT_IRQ_EN];
            ctrl.fast   <= wdata[BIT_FAST];
        end
    end

    // Reload register update, truncated to the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       reload <= '0;
        else if (wr && reg_sel_e'(sel) == SEL_RELOAD)     reload <= wdata[CNT_W-1:0];
    end

    assign wr_cur  = wr && (reg_sel_e'(sel) == SEL_CURRENT);
    assign rd_ctrl = rd && (reg_sel_e'(sel) == SEL_CTRL);

    // Read multiplexer for the selected register.
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_CTRL: begin
                rdata[BIT_RUN]    = ctrl.run;
                rdata[BIT_IRQ_EN] = ctrl.irq_en;
                rdata[BIT_FAST]   = ctrl.fast;
                rdata[BIT_FLAG]   = flag;
            end
            SEL_RELOAD:  rdata[CNT_W-1:0] = reload;
            SEL_CURRENT: rdata[CNT_W-1:0] = cur;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer_core.sv
`timescale 1ns/1ps
// Down counter with auto-reload and sticky end-of-count flag.
// Assumes tick, wr_cur and rd_ctrl are single-cycle qualifiers in clk.
module tick_timer_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             wr_cur,
    input  logic             rd_ctrl,
    output logic [CNT_W-1:0] cur,
    output logic             flag
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic hit;
    assign hit = tick && !wr_cur && (cur == ONE);

    // Counter: software clear first, else reload at zero or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)            cur <= '0;
        else if (wr_cur)       cur <= '0;
        else if (tick) begin
            if (cur == '0)     cur <= reload;
            else               cur <= cur - ONE;
        end
    end

    // Flag: a new end of count beats any clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag <= 1'b0;
        else if (hit)               flag <= 1'b1;
        else if (wr_cur || rd_ctrl) flag <= 1'b0;
    end

endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
// Top of the auto-reload tick timer: registers, divide-by-DIV enable and
// counter core, with a level interrupt from flag and enable.
// Assumes one clock domain and a synchronous active-low reset.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int DIV    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tick_irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cur_q;
    logic             flag_q;
    logic             wr_cur;
    logic             rd_ctrl;
    logic             slow_pulse;
    logic             tick;

    tick_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (reg_addr),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .wdata   (reg_wdata),
        .cur     (cur_q),
        .flag    (flag_q),
        .ctrl    (ctrl),
        .reload  (reload_q),
        .wr_cur  (wr_cur),
        .rd_ctrl (rd_ctrl),
        .rdata   (reg_rdata)
    );

    tick_timer_prescale #(.DIV(DIV)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.run),
        .pulse (slow_pulse)
    );

    assign tick = ctrl.run && (ctrl.fast || slow_pulse);

    tick_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .reload  (reload_q),
        .wr_cur  (wr_cur),
        .rd_ctrl (rd_ctrl),
        .cur     (cur_q),
        .flag    (flag_q)
    );

    assign tick_irq = flag_q && ctrl.irq_en;

endmodule

// File: rtl/tick_timer_checker.sv
`timescale 1ns/1ps
// Property checker for the tick timer, attached to the top by bind.
// Assumes the select encoding of tick_timer_pkg.
module tick_timer_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sel,
    input logic             wr,
    input logic             rd,
    input logic             run,
    input logic             fast,
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] reload,
    input logic             flag,
    input logic             irq
);

    logic cur_write;
    logic ctrl_read;
    assign cur_write = wr && (sel == 2'd2);
    assign ctrl_read = rd && (sel == 2'd0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fast && cur != '0 && !cur_write) |=> (cur == $past(cur) - CNT_W'(1)));

    p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cur == '0 && $past(cur) == CNT_W'(1)));

    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(ctrl_read || cur_write));

    p_cur_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_write |=> (cur == '0 && !flag));

    p_zero_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == '0 && reload == '0) |=> (cur == '0));

    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cur_write) |=> $stable(cur));

endmodule

bind tick_timer tick_timer_checker #(.CNT_W(CNT_W)) u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (reg_addr),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .run    (ctrl.run),
    .fast   (ctrl.fast),
    .cur    (cur_q),
    .reload (reload_q),
    .flag   (flag_q),
    .irq    (tick_irq)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_wr_cyc = 0;
    int rises[$];
    bit irq_prev = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    int m_cur, m_rel, m_pre;
    bit m_run, m_ie, m_fast, m_flag;

    always #2.5 clk = ~clk;

    tick_timer i_tick_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick_irq(tick_irq)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model: advances on every edge from the driven inputs.
    always @(posedge clk) begin
        bit tk, wcur, rctl, set_now;
        if (!rst_n) begin
            m_cur = 0; m_rel = 0; m_pre = 0;
            m_run = 0; m_ie = 0; m_fast = 0; m_flag = 0;
        end else begin
            tk      = m_run && (m_fast || m_pre == 7);
            wcur    = reg_wr && reg_addr == 2;
            rctl    = reg_rd && reg_addr == 0;
            set_now = 0;
            if (wcur) m_cur = 0;
            else if (tk) begin
                if (m_cur == 0) m_cur = m_rel;
                else begin
                    if (m_cur == 1) set_now = 1;
                    m_cur = m_cur - 1;
                end
            end
            if (set_now) m_flag = 1;
            else if (wcur || rctl) m_flag = 0;
            m_pre = m_run ? (m_pre + 1) % 8 : 0;
            if (reg_wr && reg_addr == 1) m_rel = reg_wdata & 32'h00FF_FFFF;
            if (reg_wr && reg_addr == 0) begin
                m_run = reg_wdata[0]; m_ie = reg_wdata[1]; m_fast = reg_wdata[2];
            end
        end
    end

    // Per-cycle comparison against the model, plus interrupt edge log.
    always @(negedge clk) begin
        longint exp_rd;
        if (rst_n && cyc >= 2) begin
            chk("R7 irq level", tick_irq, m_flag && m_ie);
            case (reg_addr)
                2'd0: exp_rd = (longint'(m_flag) << 16) | (m_fast << 2) | (m_ie << 1) | m_run;
                2'd1: exp_rd = m_rel;
                2'd2: exp_rd = m_cur;
                default: exp_rd = 0;
            endcase
            case (reg_addr)
                2'd0: chk("R4 control readback", reg_rdata, exp_rd);
                2'd1: chk("R10 reload readback", reg_rdata, exp_rd);
                2'd2: chk("R2 current readback", reg_rdata, exp_rd);
                default: chk("R1 spare readback", reg_rdata, exp_rd);
            endcase
            if (tick_irq && !irq_prev) rises.push_back(cyc);
            irq_prev = tick_irq;
        end
    end

    // All tasks start and end one time unit after a rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        last_wr_cyc = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_rise(output int t);
        int n = rises.size();
        do begin @(negedge clk); #1; end while (rises.size() <= n);
        t = rises[n];
        @(posedge clk); #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #750000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] v, a;
        int e, t0, t1;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 control after reset", v, 0);
        rd(2'd1, v); chk("R1 reload after reset", v, 0);
        rd(2'd2, v); chk("R1 current after reset", v, 0);
        rd(2'd3, v); chk("R1 spare address", v, 0);
        chk("R1 irq after reset", tick_irq, 0);

        // R10 width masking
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R10 reload masked to 24 bits", v, 32'h00FF_FFFF);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R10 control unused bits zero", v, 32'h7);
        wr(2'd0, 32'h0);

        // R3 / R4 fast source, reload 4
        wr(2'd1, 32'd4);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h7);
        e = last_wr_cyc;
        wait_rise(t0);
        chk("R3 first flag delay", t0 - e, 5);
        rd(2'd0, v); chk("R4 flag reads set", v, 32'h0001_0007);
        rd(2'd0, v); chk("R4 flag cleared by read", v[16], 0);
        wait_rise(t1);
        chk("R3 flag period reload+1", t1 - t0, 5);
        rd(2'd0, v);
        while (cyc < t1 + 4) begin @(posedge clk); #1; end
        rd(2'd0, v); chk("R4 flag clear before collision", v[16], 0);
        rd(2'd0, v); chk("R4 set wins over read clear", v[16], 1);

        // R5 write to current
        wait_rise(t0);
        wr(2'd2, 32'd123);
        rd(2'd2, v); chk("R5 current forced to zero", v, 0);
        rd(2'd2, v); chk("R5 next tick loads reload", v, 4);
        rd(2'd0, v); chk("R5 flag cleared by write", v, 32'h7);

        // R7 level interrupt
        wr(2'd0, 32'h5);
        wr(2'd2, 32'd0);
        idle(12);
        chk("R7 irq masked while flag set", tick_irq, 0);
        wr(2'd0, 32'h7);
        chk("R7 irq rises on enable", tick_irq, 1);

        // R8 divided source
        wr(2'd0, 32'h0);
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h3);
        e = last_wr_cyc;
        wait_rise(t0);
        chk("R8 first flag after enable", t0 - e, 24);
        rd(2'd0, v);
        wait_rise(t1);
        chk("R8 divided period", t1 - t0, 24);

        // R9 hold while stopped, reload write leaves count alone
        wr(2'd0, 32'h0);
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd9);
        wr(2'd0, 32'h5);
        idle(4);
        wr(2'd0, 32'h0);
        rd(2'd2, a); chk("R9 count at stop", a, 5);
        idle(10);
        rd(2'd2, v); chk("R9 count held", v, a);
        wr(2'd1, 32'd3);
        rd(2'd2, v); chk("R9 reload write keeps count", v, a);

        // R6 zero reload stops counting
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h5);
        idle(20);
        rd(2'd2, v); chk("R6 counter parked at zero", v, 0);
        rd(2'd0, v); chk("R6 single flag raised", v[16], 1);
        idle(20);
        rd(2'd0, v); chk("R6 no further flag", v[16], 0);
        rd(2'd2, v); chk("R6 still zero", v, 0);

        // R2 stepping after reload
        wr(2'd1, 32'd100);
        wr(2'd2, 32'd0);
        rd(2'd2, v); chk("R2 zero after clear", v, 0);
        rd(2'd2, v); chk("R2 loads reload from zero", v, 100);
        rd(2'd2, v); chk("R2 steps down by one", v, 99);

        idle(3);
        summary();
    end

endmodule